// File: doc/BRIEF.md
# General-Purpose I/O Bank with Event Detection

This block is a bank of 32 general-purpose I/O lines managed through a small register bus. Each line can be set as an input or as an output. Output values can be written as a whole word, or changed bit by bit through a set alias and a clear alias. Because each alias touches only the bits written as 1, separate software threads can drive different lines without a read-modify-write race. Pad inputs pass through a two-flop synchronizer. The synchronized word can be read back, and it also feeds the event logic.

Each line has four detect conditions, and each can be enabled on its own: input low, input high, rising edge and falling edge. When any enabled condition is met, the line's bit is set in a sticky status word. Software clears that bit by writing 1 to it. The status word is masked by two independent enable words, which drive two interrupt outputs. A third mask drives a wake request. Debounce filtering sits ahead of this block and is not part of it.

The bus accepts one request per `busValid` cycle. `busReady` is raised in the cycle that follows, and for a read the data is on `busRdata` in that same cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction word is all ones, so every line is an input and `padOe` is 0. The output word, all detect, interrupt and wake enables, and the status word are all 0. `irqA`, `irqB` and `wakeReq` are low.
- R2: The direction word is at byte offset 0x00. A direction bit of 1 makes its line an input and a bit of 0 makes it an output. `padOe` is the inverse of the direction word and changes only in the cycle after a direction write.
- R3: The output word is at offset 0x08. A write there replaces the whole word, and `padOut` shows the new value in the next cycle.
- R4: Writing to the set alias at 0x0C ORs the written bits into the output word. Bits written as 0 keep their value.
- R5: Writing to the clear alias at 0x10 clears each output bit that is written as 1. Bits written as 0 keep their value.
- R6: The following all read as 0: the set and clear aliases, any offset above 0x30, and any offset not aligned to a word. The synchronized input word at 0x04 is read-only, and writes to it have no effect.
- R7: A read of 0x04 returns the pad inputs after two synchronizer flops. A pad change driven just before clock edge k can first be read by a request sampled at edge k+2.
- R8: The low-level enable is at 0x14 and the high-level enable is at 0x18. While a line's synchronized input is at an enabled level, its bit is set in the status word at 0x24.
- R9: The rising-edge enable is at 0x1C and the falling-edge enable is at 0x20. One 0-to-1 or 1-to-0 change of the synchronized input sets the status bit, and the bit stays set after the input returns.
- R10: Writing 1 to a status bit clears it. A condition that is active in the same cycle wins, so the bit stays set. Bits written as 0 keep their value.
- R11: `irqA` is high when any status bit is also set in the enable word at 0x28. `irqB` does the same with the enable word at 0x2C. The two outputs are independent.
- R12: `wakeReq` is high when any status bit is also set in the wake mask at 0x30.
- R13: `busReady` is high in the cycle after each cycle with `busValid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus request in this cycle |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while `busReady` is high |
| busReady | output | 1 | Response strobe, one cycle after the request |
| padIn | input | 32 | Asynchronous pad inputs |
| padOut | output | 32 | Output values to the pads |
| padOe | output | 32 | Output enable per line, 1 = drive |
| irqA | output | 1 | First masked interrupt |
| irqB | output | 1 | Second masked interrupt |
| wakeReq | output | 1 | Masked wake request |

## Verification
The bound checker runs on every cycle and covers these port-level rules:
- the response strobe timing;
- `padOe` following direction writes, and holding steady without them;
- the whole-word, set-alias and clear-alias updates of `padOut`;
- the zero read-back of the aliases.

The synchronizer latency, the four detect modes, the sticky status with set-over-clear priority, and the masking onto the interrupt and wake outputs all depend on pad sequences and register contents. Only the bench's scenarios show those, compared cycle by cycle against its behavioural model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word index of each register (byte offset / 4).
  localparam int REG_DIR  = 0;
  localparam int REG_DIN  = 1;
  localparam int REG_DOUT = 2;
  localparam int REG_SET  = 3;
  localparam int REG_CLR  = 4;
  localparam int REG_DET0 = 5;   // first of the four detect enable words
  localparam int REG_STAT = 9;
  localparam int REG_ENA  = 10;
  localparam int REG_ENB  = 11;
  localparam int REG_WAKE = 12;
  localparam int REG_LAST = REG_WAKE;

  localparam int NUM_DET  = 4;
  localparam int SEL_W    = 4;

  // Detect kinds, in the order of their enable words.
  typedef enum logic [1:0] {
    DET_LOW  = 2'd0,
    DET_HIGH = 2'd1,
    DET_RISE = 2'd2,
    DET_FALL = 2'd3
  } detKind_t;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic               wrDir;
    logic               wrOut;
    logic               wrSet;
    logic               wrClr;
    logic [NUM_DET-1:0] wrDet;
    logic               wrStat;
    logic               wrEnA;
    logic               wrEnB;
    logic               wrWake;
    logic               rdHit;
    logic               rdStrobe;
    logic [SEL_W-1:0]   rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[g] <= '0;
      else       stageQ[g] <= stageQ[g-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_bank_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0]              level,
  input  logic [LINES-1:0]              prevLevel,
  input  logic [NUM_DET-1:0][LINES-1:0] detEn,
  output logic [LINES-1:0]              hit
);

  for (genvar i = 0; i < LINES; i++) begin : gLine
    logic isLow, isHigh, isRise, isFall;
    always_comb begin
      isLow  = detEn[DET_LOW][i]  & ~level[i];
      isHigh = detEn[DET_HIGH][i] &  level[i];
      isRise = detEn[DET_RISE][i] &  level[i] & ~prevLevel[i];
      isFall = detEn[DET_FALL][i] & ~level[i] &  prevLevel[i];
    end
    assign hit[i] = isLow | isHigh | isRise | isFall;
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes,
  output logic              busReady
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             mapped;
  logic             wrGo;

  always_comb begin
    wordIdx = busAddr[ADDR_W-1:2];
    aligned = (busAddr[1:0] == 2'b00);
    mapped  = aligned && (wordIdx <= IDX_W'(REG_LAST));
    wrGo    = busValid && busWe && mapped;

    strobes          = '0;
    strobes.wrDir    = wrGo && (wordIdx == IDX_W'(REG_DIR));
    strobes.wrOut    = wrGo && (wordIdx == IDX_W'(REG_DOUT));
    strobes.wrSet    = wrGo && (wordIdx == IDX_W'(REG_SET));
    strobes.wrClr    = wrGo && (wordIdx == IDX_W'(REG_CLR));
    for (int k = 0; k < NUM_DET; k++) begin
      strobes.wrDet[k] = wrGo && (wordIdx == IDX_W'(REG_DET0 + k));
    end
    strobes.wrStat   = wrGo && (wordIdx == IDX_W'(REG_STAT));
    strobes.wrEnA    = wrGo && (wordIdx == IDX_W'(REG_ENA));
    strobes.wrEnB    = wrGo && (wordIdx == IDX_W'(REG_ENB));
    strobes.wrWake   = wrGo && (wordIdx == IDX_W'(REG_WAKE));
    strobes.rdStrobe = busValid;
    strobes.rdHit    = busValid && !busWe && mapped;
    strobes.rdSel    = wordIdx[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busValid;
  end

endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_bank_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] padIn,
  output logic [LINES-1:0] padOut,
  output logic [LINES-1:0] padOe,
  output logic [LINES-1:0] rdData,
  output logic             irqA,
  output logic             irqB,
  output logic             wakeReq
);

  logic [LINES-1:0]              dirQ;
  logic [LINES-1:0]              outQ;
  logic [NUM_DET-1:0][LINES-1:0] detEnQ;
  logic [LINES-1:0]              statusQ;
  logic [LINES-1:0]              enAQ;
  logic [LINES-1:0]              enBQ;
  logic [LINES-1:0]              wakeQ;
  logic [LINES-1:0]              inSync;
  logic [LINES-1:0]              prevQ;
  logic [LINES-1:0]              hit;
  logic [LINES-1:0]              clrMask;
  logic [LINES-1:0]              rdMux;

  gpio_sync #(
    .WIDTH (LINES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (padIn),
    .dout(inSync)
  );

  gpio_detect #(
    .LINES(LINES)
  ) u_detect (
    .level    (inSync),
    .prevLevel(prevQ),
    .detEn    (detEnQ),
    .hit      (hit)
  );

  // Previous synchronized sample for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= inSync;
  end

  // Direction word: 1 = input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dirQ <= '1;
    else if (strobes.wrDir) dirQ <= wdata;
  end

  // Output word with whole-word write and atomic set / clear aliases.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outQ <= '0;
    else if (strobes.wrOut) outQ <= wdata;
    else if (strobes.wrSet) outQ <= outQ | wdata;
    else if (strobes.wrClr) outQ <= outQ & ~wdata;
  end

  for (genvar k = 0; k < NUM_DET; k++) begin : gDetReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 detEnQ[k] <= '0;
      else if (strobes.wrDet[k]) detEnQ[k] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enAQ  <= '0;
      enBQ  <= '0;
      wakeQ <= '0;
    end else begin
      if (strobes.wrEnA)  enAQ  <= wdata;
      if (strobes.wrEnB)  enBQ  <= wdata;
      if (strobes.wrWake) wakeQ <= wdata;
    end
  end

  // Sticky status: write-one-to-clear, a fresh hit wins over the clear.
  assign clrMask = strobes.wrStat ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | hit;
  end

  // Read mux and registered response.
  always_comb begin
    rdMux = '0;
    if (strobes.rdHit) begin
      case (strobes.rdSel)
        SEL_W'(REG_DIR):      rdMux = dirQ;
        SEL_W'(REG_DIN):      rdMux = inSync;
        SEL_W'(REG_DOUT):     rdMux = outQ;
        SEL_W'(REG_DET0 + 0): rdMux = detEnQ[0];
        SEL_W'(REG_DET0 + 1): rdMux = detEnQ[1];
        SEL_W'(REG_DET0 + 2): rdMux = detEnQ[2];
        SEL_W'(REG_DET0 + 3): rdMux = detEnQ[3];
        SEL_W'(REG_STAT):     rdMux = statusQ;
        SEL_W'(REG_ENA):      rdMux = enAQ;
        SEL_W'(REG_ENB):      rdMux = enBQ;
        SEL_W'(REG_WAKE):     rdMux = wakeQ;
        default:              rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= rdMux;
  end

  assign padOut  = outQ;
  assign padOe   = ~dirQ;
  assign irqA    = |(statusQ & enAQ);
  assign irqB    = |(statusQ & enBQ);
  assign wakeReq = |(statusQ & wakeQ);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  output logic              busReady,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  padOut,
  output logic [LINES-1:0]  padOe,
  output logic              irqA,
  output logic              irqB,
  output logic              wakeReq
);

  ctrlStrobes_t strobes;

  gpio_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes),
    .busReady(busReady)
  );

  gpio_dp #(
    .LINES      (LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (busWdata),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .rdData (busRdata),
    .irqA   (irqA),
    .irqB   (irqB),
    .wakeReq(wakeReq)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [LINES-1:0]  busWdata,
  input logic [LINES-1:0]  busRdata,
  input logic              busReady,
  input logic [LINES-1:0]  padOut,
  input logic [LINES-1:0]  padOe
);

  logic wrDirReq, wrOutReq, wrSetReq, wrClrReq, rdAliasReq;

  assign wrDirReq   = busValid && busWe && (busAddr == ADDR_W'(8'h00));
  assign wrOutReq   = busValid && busWe && (busAddr == ADDR_W'(8'h08));
  assign wrSetReq   = busValid && busWe && (busAddr == ADDR_W'(8'h0C));
  assign wrClrReq   = busValid && busWe && (busAddr == ADDR_W'(8'h10));
  assign rdAliasReq = busValid && !busWe &&
                      ((busAddr == ADDR_W'(8'h0C)) || (busAddr == ADDR_W'(8'h10)));

  assert_ready_R13: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busReady);

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busReady);

  assert_oe_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrDirReq |=> (padOe == ~$past(busWdata)));

  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrDirReq |=> $stable(padOe));

  assert_out_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrOutReq |=> (padOut == $past(busWdata)));

  assert_out_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrSetReq |=> (padOut == ($past(padOut) | $past(busWdata))));

  assert_out_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrClrReq |=> (padOut == ($past(padOut) & ~$past(busWdata))));

  assert_alias_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdAliasReq |=> (busRdata == '0));

endmodule

bind gpio_bank gpio_bank_chk #(
  .ADDR_W(ADDR_W),
  .LINES (LINES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .busReady(busReady),
  .padOut  (padOut),
  .padOe   (padOe)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irqA, irqB, wakeReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_bank u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .busReady(busReady),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .irqA    (irqA),
    .irqB    (irqB),
    .wakeReq (wakeReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mRegs [0:12];   // indexed by word offset
  logic [31:0] s1, s2, prev;
  logic [31:0] mRd;
  logic        mReady;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r <= 12; r++) mRegs[r] = 32'h0;
      mRegs[0] = 32'hFFFF_FFFF;
      s1 = 0; s2 = 0; prev = 0; mRd = 0; mReady = 0;
    end else begin
      logic [31:0] ev;
      int idx;
      ev = 0;
      for (int b = 0; b < 32; b++) begin
        if (mRegs[5][b] && !s2[b])            ev[b] = 1'b1;
        if (mRegs[6][b] && s2[b])             ev[b] = 1'b1;
        if (mRegs[7][b] && s2[b] && !prev[b]) ev[b] = 1'b1;
        if (mRegs[8][b] && !s2[b] && prev[b]) ev[b] = 1'b1;
      end
      idx = busAddr / 4;
      mReady = busValid;
      if (busValid) begin
        mRd = 0;
        if (!busWe && busAddr % 4 == 0 && idx <= 12) begin
          if (idx == 1)                 mRd = s2;
          else if (idx == 3 || idx == 4) mRd = 0;
          else                          mRd = mRegs[idx];
        end
      end
      if (busValid && busWe && busAddr % 4 == 0 && idx <= 12) begin
        case (idx)
          1:       ;
          3:       mRegs[2] = mRegs[2] | busWdata;
          4:       mRegs[2] = mRegs[2] & ~busWdata;
          9:       mRegs[9] = mRegs[9] & ~busWdata;
          default: mRegs[idx] = busWdata;
        endcase
      end
      mRegs[9] = mRegs[9] | ev;
      prev = s2; s2 = s1; s1 = padIn;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 padOut", padOut, mRegs[2]);
      check("R2 padOe", padOe, ~mRegs[0]);
      check("R11 irqA", {31'b0, irqA}, {31'b0, |(mRegs[9] & mRegs[10])});
      check("R11 irqB", {31'b0, irqB}, {31'b0, |(mRegs[9] & mRegs[11])});
      check("R12 wakeReq", {31'b0, wakeReq}, {31'b0, |(mRegs[9] & mRegs[12])});
      check("R13 busReady", {31'b0, busReady}, {31'b0, mReady});
      if (mReady) check("R6 busRdata", busRdata, mRd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic setPads(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    check("R1 irq/wake", {29'b0, irqA, irqB, wakeReq}, 32'h0);
    busRead(8'h00, rd); check("R1 dir reset", rd, 32'hFFFF_FFFF);
    busRead(8'h24, rd); check("R1 status reset", rd, 32'h0);

    // R13: response strobe timing
    @(negedge clk); busValid = 1'b1; busWe = 1'b0; busAddr = 8'h00;
    @(negedge clk); busValid = 1'b0;
    check("R13 ready after request", {31'b0, busReady}, 32'h1);
    @(negedge clk);
    check("R13 ready drops", {31'b0, busReady}, 32'h0);

    // R2: direction
    busWrite(8'h00, 32'hFFFF_0000);
    check("R2 padOe inverse", padOe, 32'h0000_FFFF);

    // R3 / R4 / R5: output word and aliases
    busWrite(8'h08, 32'h0000_00F0);
    check("R3 padOut word", padOut, 32'h0000_00F0);
    busWrite(8'h0C, 32'h0F00_0003);
    busRead(8'h08, rd); check("R4 set alias", rd, 32'h0F00_00F3);
    busWrite(8'h10, 32'h0000_00A1);
    busRead(8'h08, rd); check("R5 clear alias", rd, 32'h0F00_0052);

    // R6: zero reads
    busRead(8'h0C, rd); check("R6 set alias reads 0", rd, 32'h0);
    busRead(8'h10, rd); check("R6 clear alias reads 0", rd, 32'h0);
    busRead(8'h34, rd); check("R6 unmapped reads 0", rd, 32'h0);
    busRead(8'h02, rd); check("R6 unaligned reads 0", rd, 32'h0);

    // R7: synchronizer latency
    setPads(32'h1234_5678);
    busRead(8'h04, rd); check("R7 still old after one stage", rd, 32'h0);
    busRead(8'h04, rd); check("R7 new after two stages", rd, 32'h1234_5678);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busRead(8'h04, rd); check("R6 data-in write ignored", rd, 32'h1234_5678);

    // R8: level detection
    setPads(32'h0);
    repeat (3) @(negedge clk);
    busWrite(8'h18, 32'h0000_0001);
    busWrite(8'h14, 32'h0000_0002);
    setPads(32'h0000_0001);
    repeat (4) @(negedge clk);
    busRead(8'h24, rd); check("R8 high and low level", rd, 32'h0000_0003);

    // R10: clear with condition still active, then inactive
    busWrite(8'h24, 32'h0000_0003);
    busRead(8'h24, rd); check("R10 active level re-sets", rd, 32'h0000_0003);
    busWrite(8'h14, 32'h0);
    busWrite(8'h18, 32'h0);
    busWrite(8'h24, 32'h0000_0002);
    busRead(8'h24, rd); check("R10 partial clear", rd, 32'h0000_0001);
    busWrite(8'h24, 32'hFFFF_FFFF);
    busRead(8'h24, rd); check("R10 cleared", rd, 32'h0);

    // R9: edge detection
    busWrite(8'h1C, 32'h0000_0020);
    busWrite(8'h20, 32'h0000_0040);
    setPads(32'h0000_0041);
    repeat (4) @(negedge clk);
    busRead(8'h24, rd); check("R9 no edge yet", rd, 32'h0);
    setPads(32'h0000_0020);
    setPads(32'h0000_0000);
    repeat (4) @(negedge clk);
    busRead(8'h24, rd); check("R9 rise and fall sticky", rd, 32'h0000_0060);

    // R11: two independent interrupt masks
    busWrite(8'h28, 32'h0000_0020);
    check("R11 irqA on", {31'b0, irqA}, 32'h1);
    check("R11 irqB off", {31'b0, irqB}, 32'h0);
    busWrite(8'h2C, 32'h0000_0040);
    check("R11 irqB on", {31'b0, irqB}, 32'h1);

    // R12: wake mask
    check("R12 wake off", {31'b0, wakeReq}, 32'h0);
    busWrite(8'h30, 32'h0000_0040);
    check("R12 wake on", {31'b0, wakeReq}, 32'h1);
    busWrite(8'h24, 32'h0000_0040);
    check("R12 wake after clear", {31'b0, wakeReq}, 32'h0);
    check("R11 irqB after clear", {31'b0, irqB}, 32'h0);
    check("R11 irqA kept", {31'b0, irqA}, 32'h1);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule